// File: doc/BRIEF.md
# Prescaled Baud Rate Generator

This block turns a base clock into two bit-rate enable pulses for one serial channel, one for the receiver and one for the transmitter. Each direction has its own 8-bit time constant and its own 4-bit prescale exponent. The divide ratio of a direction is the effective time constant times two raised to the clamped exponent. The output is a single-cycle enable that is high once per period. It is not a derived clock.

Configuration is written through a per-direction strobe that carries both fields at once. A new setting is held in a shadow register and only goes live when the running period ends, or when the channel reset input is asserted. The channel reset clears both dividers, so the two directions can be restarted in phase. After the asynchronous chip reset, both directions come up at the slowest rate.

Top module: `bitclk_gen`

## Requirements
- R1: Each tick output is high for exactly one base-clock cycle, and consecutive ticks of a direction are exactly N cycles apart. N = T * 2^E, where T is the effective time constant and E is the effective exponent.
- R2: A time-constant field value of 0 gives T = 256. Any value from 1 to 255 gives T equal to that value.
- R3: The exponent field is a 4-bit unsigned value. Values from 0 to 9 are used as written, and values from 10 to 15 act as 9.
- R4: With a time constant of 1 and an exponent of 0, the tick is high on every cycle, which is the base-clock rate.
- R5: With a time constant of 0 and an exponent of 9, the period is 131072 cycles, the slowest rate.
- R6: The receive and transmit directions use separate settings and separate counters. A setting written to one direction has no effect on the other direction's ticks.
- R7: A configuration write does not change the period in progress. The period in progress completes at the old ratio, and the new ratio applies from the following tick on, so no shortened pulse spacing occurs.
- R8: While `chan_rst` is high, both ticks stay low and both counters are held at zero. Pending settings become live. The first tick after `chan_rst` falls appears exactly N cycles after the last clock edge at which `chan_rst` was high.
- R9: While `rst_n` is low, both ticks are low. After reset, both directions use T = 256 and E = 9 until they are reconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_rst | input | 1 | Synchronous channel reset for both dividers |
| rx_cfg_we | input | 1 | Write strobe for receive time constant and exponent |
| rx_tc | input | 8 | Receive time constant (0 means 256) |
| rx_exp | input | 4 | Receive prescale exponent (clamped to 9) |
| tx_cfg_we | input | 1 | Write strobe for transmit time constant and exponent |
| tx_tc | input | 8 | Transmit time constant (0 means 256) |
| tx_exp | input | 4 | Transmit prescale exponent (clamped to 9) |
| rx_tick | output | 1 | Receive bit-rate enable pulse |
| tx_tick | output | 1 | Transmit bit-rate enable pulse |

## Verification
A tick is registered, so the first tick after `chan_rst` falls appears N edges after the last edge that sampled `chan_rst` high. Every later tick follows the previous one by N edges. The bench captures the cycle count at the falling edge where it releases `chan_rst`. A monitor timestamps each tick at falling edges, and the bench compares every timestamp with that start count plus a multiple of N, where N comes from a bench function. For a write made in the middle of a period, the expected times are the old N once more and then the new N.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  localparam int unsigned DEF_TC_W    = 8;
  localparam int unsigned DEF_EXP_W   = 4;
  localparam int unsigned DEF_EXP_MAX = 9;
  localparam int unsigned NDIR        = 2;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } bitclk_dir_e;
endpackage

// File: rtl/bitclk_cfg.sv
module bitclk_cfg #(
  parameter int unsigned TC_W    = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wrap,
  input  logic             wr_en,
  input  logic [TC_W-1:0]  wr_tc,
  input  logic [EXP_W-1:0] wr_exp,
  output logic [TC_W:0]    tc_eff,
  output logic [EXP_W-1:0] exp_eff
);
  localparam int unsigned TCE_W = TC_W + 1;
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_MAX);

  logic [TC_W-1:0]  shd_tc_q,  shd_tc_d;
  logic [EXP_W-1:0] shd_exp_q, shd_exp_d;
  logic [TC_W-1:0]  act_tc_q,  act_tc_d;
  logic [EXP_W-1:0] act_exp_q, act_exp_d;
  logic             load;

  // shadow capture and live-copy reload
  always_comb begin
    shd_tc_d  = shd_tc_q;
    shd_exp_d = shd_exp_q;
    if (wr_en) begin
      shd_tc_d  = wr_tc;
      shd_exp_d = wr_exp;
    end
    load      = clr | wrap;
    act_tc_d  = act_tc_q;
    act_exp_d = act_exp_q;
    if (load) begin
      act_tc_d  = shd_tc_d;
      act_exp_d = (shd_exp_d > EXP_LIM) ? EXP_LIM : shd_exp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_tc_q  <= '0;
      shd_exp_q <= EXP_LIM;
      act_tc_q  <= '0;
      act_exp_q <= EXP_LIM;
    end else begin
      shd_tc_q  <= shd_tc_d;
      shd_exp_q <= shd_exp_d;
      act_tc_q  <= act_tc_d;
      act_exp_q <= act_exp_d;
    end
  end

  assign tc_eff  = (act_tc_q == '0) ? TCE_W'(1 << TC_W) : {1'b0, act_tc_q};
  assign exp_eff = act_exp_q;

  AST_EXP_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    act_exp_q <= EXP_LIM); // R3

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || wrap) |=> ($stable(act_tc_q) && $stable(act_exp_q))); // R7
endmodule

// File: rtl/bitclk_div.sv
module bitclk_div #(
  parameter int unsigned TC_W    = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [TC_W:0]    tc_eff,
  input  logic [EXP_W-1:0] exp_eff,
  output logic             wrap,
  output logic             tick
);
  localparam int unsigned TCE_W = TC_W + 1;
  localparam int unsigned PRE_W = EXP_MAX;

  logic [TC_W-1:0]  cnt_tc_q,  cnt_tc_d;
  logic [PRE_W-1:0] cnt_pre_q, cnt_pre_d;
  logic [PRE_W-1:0] pre_lim;
  logic             tc_last, pre_last;
  logic             tick_q, tick_d;

  // last prescale count is 2^exp - 1
  assign pre_lim  = ~({PRE_W{1'b1}} << exp_eff);
  assign tc_last  = ({1'b0, cnt_tc_q} == (tc_eff - TCE_W'(1)));
  assign pre_last = (cnt_pre_q == pre_lim);
  assign wrap     = tc_last & pre_last & ~clr;

  always_comb begin
    cnt_tc_d  = cnt_tc_q;
    cnt_pre_d = cnt_pre_q;
    if (clr) begin
      cnt_tc_d  = '0;
      cnt_pre_d = '0;
    end else if (tc_last) begin
      cnt_tc_d  = '0;
      cnt_pre_d = pre_last ? '0 : (cnt_pre_q + PRE_W'(1));
    end else begin
      cnt_tc_d  = cnt_tc_q + TC_W'(1);
    end
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_tc_q  <= '0;
      cnt_pre_q <= '0;
      tick_q    <= 1'b0;
    end else begin
      cnt_tc_q  <= cnt_tc_d;
      cnt_pre_q <= cnt_pre_d;
      tick_q    <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_TC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_tc_q} < tc_eff); // R1

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pre_q <= pre_lim); // R1

  AST_TICK_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (cnt_tc_q == '0 && cnt_pre_q == '0)); // R1

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tick_q && cnt_tc_q == '0 && cnt_pre_q == '0)); // R8

  AST_UNITY_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_eff == TCE_W'(1) && exp_eff == '0 && !clr) |=> tick_q); // R4
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int unsigned TC_W    = DEF_TC_W,
  parameter int unsigned EXP_W   = DEF_EXP_W,
  parameter int unsigned EXP_MAX = DEF_EXP_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_rst,
  input  logic             rx_cfg_we,
  input  logic [TC_W-1:0]  rx_tc,
  input  logic [EXP_W-1:0] rx_exp,
  input  logic             tx_cfg_we,
  input  logic [TC_W-1:0]  tx_tc,
  input  logic [EXP_W-1:0] tx_exp,
  output logic             rx_tick,
  output logic             tx_tick
);
  localparam int unsigned IRX = int'(DIR_RX);
  localparam int unsigned ITX = int'(DIR_TX);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             we_a   [NDIR];
  logic [TC_W-1:0]  tc_a   [NDIR];
  logic [EXP_W-1:0] exp_a  [NDIR];
  logic             tick_a [NDIR];

  assign we_a[IRX]  = rx_cfg_we;
  assign tc_a[IRX]  = rx_tc;
  assign exp_a[IRX] = rx_exp;
  assign we_a[ITX]  = tx_cfg_we;
  assign tc_a[ITX]  = tx_tc;
  assign exp_a[ITX] = tx_exp;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [TC_W:0]    tc_eff;
    logic [EXP_W-1:0] exp_eff;
    logic             wrap;

    bitclk_cfg #(.TC_W(TC_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr     (chan_rst),
      .wrap    (wrap),
      .wr_en   (we_a[d]),
      .wr_tc   (tc_a[d]),
      .wr_exp  (exp_a[d]),
      .tc_eff  (tc_eff),
      .exp_eff (exp_eff)
    );

    bitclk_div #(.TC_W(TC_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_div (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr     (chan_rst),
      .tc_eff  (tc_eff),
      .exp_eff (exp_eff),
      .wrap    (wrap),
      .tick    (tick_a[d])
    );
  end

  assign rx_tick = tick_a[IRX];
  assign tx_tick = tick_a[ITX];

  AST_RESET_SILENT: assert property (@(posedge clk)
    !rst_sync_q[0] |-> (!rx_tick && !tx_tick)); // R9
endmodule

// File: tb/bitclk_gen_tb_top.sv
module bitclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_rst = 1'b0;
  logic       rx_cfg_we = 1'b0, tx_cfg_we = 1'b0;
  logic [7:0] rx_tc = '0, tx_tc = '0;
  logic [3:0] rx_exp = '0, tx_exp = '0;
  logic       rx_tick, tx_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rx_cnt = 0, tx_cnt = 0;
  int rx_t [64];
  int tx_t [64];

  always #2.5ns clk = ~clk;

  bitclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
    .rx_cfg_we(rx_cfg_we), .rx_tc(rx_tc), .rx_exp(rx_exp),
    .tx_cfg_we(tx_cfg_we), .tx_tc(tx_tc), .tx_exp(tx_exp),
    .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_tick) begin rx_t[rx_cnt % 64] = cyc; rx_cnt = rx_cnt + 1; end
    if (tx_tick) begin tx_t[tx_cnt % 64] = cyc; tx_cnt = tx_cnt + 1; end
  end

  function automatic int period(input int tc, input int ex);
    int t = (tc == 0) ? 256 : tc;
    int e = (ex > 9) ? 9 : ex;
    return t << e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1ms;
  end

  always @(posedge clk) begin
    if (cyc > 195000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
      summary();
    end
  end

  task automatic write_cfg(input int rtc, input int rex, input int ttc, input int tex);
    @(negedge clk);
    rx_cfg_we = 1'b1; rx_tc = 8'(rtc); rx_exp = 4'(rex);
    tx_cfg_we = 1'b1; tx_tc = 8'(ttc); tx_exp = 4'(tex);
    @(negedge clk);
    rx_cfg_we = 1'b0; tx_cfg_we = 1'b0;
  endtask

  // pulse channel reset; returns the release cycle and the log bases
  task automatic restart(output int t0, output int rb, output int tb);
    @(negedge clk);
    chan_rst = 1'b1;
    @(negedge clk);
    chan_rst = 1'b0;
    #1ns;
    t0 = cyc; rb = rx_cnt; tb = tx_cnt;
  endtask

  task automatic run_pair(input int rtc, input int rex, input int ttc, input int tex,
                          input int nt, input string req);
    int t0, rb, tb, nr, nx;
    nr = period(rtc, rex);
    nx = period(ttc, tex);
    write_cfg(rtc, rex, ttc, tex);
    restart(t0, rb, tb);
    while (rx_cnt < rb + nt || tx_cnt < tb + nt) @(negedge clk);
    #1ns;
    for (int k = 0; k < nt; k++) begin
      chk(rx_t[(rb + k) % 64] == t0 + (k + 1) * nr, {req, " rx"},
          rx_t[(rb + k) % 64], t0 + (k + 1) * nr);
      chk(tx_t[(tb + k) % 64] == t0 + (k + 1) * nx, {req, " tx"},
          tx_t[(tb + k) % 64], t0 + (k + 1) * nx);
    end
  endtask

  initial begin
    int t0, rb, tb, seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    #1ns;
    // R9: ticks low while reset is held
    chk(rx_tick == 1'b0 && tx_tick == 1'b0, "R9 reset", int'(rx_tick) + int'(tx_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 / R9: default setting is the slowest rate
    restart(t0, rb, tb);
    while (rx_cnt < rb + 1 || tx_cnt < tb + 1) @(negedge clk);
    #1ns;
    chk(rx_t[rb % 64] == t0 + 131072, "R5 R9 default rx", rx_t[rb % 64], t0 + 131072);
    chk(tx_t[tb % 64] == t0 + 131072, "R5 R9 default tx", tx_t[tb % 64], t0 + 131072);

    // R4: unity ratio, every cycle
    run_pair(1, 0, 1, 0, 4, "R4 unity");
    // R2: time constant 0 means 256
    run_pair(0, 0, 0, 1, 2, "R2 tc zero");
    // R3: exponent clamp
    run_pair(1, 15, 2, 12, 2, "R3 clamp");
    run_pair(3, 9, 1, 10, 2, "R3 edge");
    // R6: independent directions
    run_pair(5, 1, 7, 0, 3, "R6 split");
    // R1: two-cycle ratio, pulses of one cycle
    run_pair(2, 0, 1, 1, 3, "R1 short");

    // R1 R6: random ratios
    for (int i = 0; i < 12; i++) begin
      int a, b, c, d;
      a = int'($urandom_range(1, 64));
      b = int'($urandom_range(0, 2));
      c = int'($urandom_range(1, 64));
      d = int'($urandom_range(0, 2));
      run_pair(a, b, c, d, 3, "R1 R6 random");
    end

    // R7: write in mid-period takes effect after the running period
    write_cfg(10, 0, 10, 0);
    restart(t0, rb, tb);
    while (rx_cnt < rb + 1) @(negedge clk);
    @(negedge clk);
    rx_cfg_we = 1'b1; rx_tc = 8'd3; rx_exp = 4'd0;
    @(negedge clk);
    rx_cfg_we = 1'b0;
    while (rx_cnt < rb + 4 || tx_cnt < tb + 3) @(negedge clk);
    #1ns;
    chk(rx_t[rb % 64] == t0 + 10, "R7 first", rx_t[rb % 64], t0 + 10);
    chk(rx_t[(rb + 1) % 64] == t0 + 20, "R7 old ratio kept", rx_t[(rb + 1) % 64], t0 + 20);
    chk(rx_t[(rb + 2) % 64] == t0 + 23, "R7 new ratio", rx_t[(rb + 2) % 64], t0 + 23);
    chk(rx_t[(rb + 3) % 64] == t0 + 26, "R7 new ratio again", rx_t[(rb + 3) % 64], t0 + 26);
    chk(tx_t[(tb + 2) % 64] == t0 + 30, "R6 tx unaffected", tx_t[(tb + 2) % 64], t0 + 30);

    // R8: held channel reset silences both directions
    write_cfg(1, 0, 1, 0);
    restart(t0, rb, tb);
    repeat (3) @(negedge clk);
    chan_rst = 1'b1;
    #1ns;
    rb = rx_cnt; tb = tx_cnt;
    repeat (6) @(negedge clk);
    #1ns;
    chk(rx_cnt == rb, "R8 hold rx", rx_cnt - rb, 0);
    chk(tx_cnt == tb, "R8 hold tx", tx_cnt - tb, 0);
    chan_rst = 1'b0;
    t0 = cyc; rb = rx_cnt; tb = tx_cnt;
    while (rx_cnt < rb + 2) @(negedge clk);
    #1ns;
    chk(rx_t[rb % 64] == t0 + 1, "R8 first after release", rx_t[rb % 64], t0 + 1);
    chk(rx_t[(rb + 1) % 64] == t0 + 2, "R8 second after release", rx_t[(rb + 1) % 64], t0 + 2);

    summary();
  end
endmodule